// File: doc/BRIEF.md
# Byte-Addressed Data Memory with Width-Checked Access

This block is a small synchronous data store for a simple processor datapath. It takes a 32-bit byte address, a 32-bit write word and a 2-bit access mode, and it answers with a 32-bit read word and an error flag. The storage is arranged as bytes in four lanes, so a write can touch one byte, two bytes or all four bytes of a word. The bytes that the access does not cover keep their contents.

The mode field encodes one read and three write widths. Each width carries its own alignment rule. An access that breaks its rule is dropped: it writes nothing, it returns no data, and it raises an error flag in the following cycle. Writes commit on the rising clock edge. Read data is combinational from the current address. The depth in bytes is a parameter. Address bits above that depth are ignored, so the address space wraps onto the storage.

Top module: `byte_data_mem`

## Requirements
- R1: While `en` is low, no byte of storage changes, `rdata` is zero and `err` is low in the next cycle, whatever `mode`, `addr` and `wdata` are.
- R2: With `en` high and `mode` = 2'b00 at an address whose two low bits are zero, `rdata` shows the stored word in the same cycle. It is little-endian: `rdata[7:0]` is the byte at the address and `rdata[31:24]` is the byte at address+3.
- R3: With `en` high and `mode` = 2'b01, `wdata[7:0]` is written to the addressed byte at any address, and the other three bytes of that word are unchanged.
- R4: With `en` high and `mode` = 2'b10 at an even address, `wdata[7:0]` goes to the address and `wdata[15:8]` goes to address+1, and the other two bytes of the word are unchanged.
- R5: With `en` high and `mode` = 2'b11 at an address whose two low bits are zero, all four bytes take `wdata`, little-endian.
- R6: A halfword write at an odd address, or a word write whose two low address bits are not zero, writes nothing. `err` is high in the cycle after that access and low again after the next access that is aligned or disabled.
- R7: A word read whose two low address bits are not zero returns zero on `rdata` and raises `err` in the next cycle.
- R8: Address bits at and above log2(DEPTH_BYTES) are ignored, so addresses that differ only in those bits reach the same byte.
- R9: Reset clears `err`. A write is visible to a read in the cycle after its clock edge.
- R10: `rdata` is zero whenever the current access is not an enabled, aligned word read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and the error flag update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the error flag |
| en | input | 1 | Access enable |
| mode | input | 2 | 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, low bits used for sub-word writes |
| rdata | output | 32 | Read word, zero unless an aligned enabled read |
| err | output | 1 | High for the cycle after a misaligned enabled access |

## Verification
The hardest case to bring about from the ports is a misaligned write that would have corrupted bytes beside it. Only a later aligned word read can show that nothing changed. The stimulus first fills every word with a known pattern. It then sends misaligned and disabled writes next to bytes that were just written by sub-word writes, and reads back each word that those writes could have touched. A long run of mixed accesses with random enable, mode and address, including high address bits, is compared every cycle against a byte-array model. This run exercises the wrapping and the cases where the error flag rises in back-to-back cycles.

// File: rtl/mem_pkg.sv
package mem_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_RD_WORD = 2'b00,
        MODE_WR_BYTE = 2'b01,
        MODE_WR_HALF = 2'b10,
        MODE_WR_WORD = 2'b11
    } mem_mode_e;

    typedef struct packed {
        logic err;
    } mem_ctl_t;
endpackage

// File: rtl/mem_access_decode.sv
module mem_access_decode
    import mem_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LSW   = 2
) (
    input  logic                    en,
    input  mem_mode_e               mode,
    input  logic [LSW-1:0]          addr_lo,
    input  logic [BYTE_W*LANES-1:0] wdata,
    output logic [LANES-1:0]        lane_we,
    output logic [BYTE_W*LANES-1:0] lane_wdata,
    output logic                    misaligned,
    output logic                    read_ok
);
    logic word_ok;
    logic half_ok;
    logic acc_ok;
    logic sel;

    always_comb begin
        word_ok = (addr_lo == '0);
        half_ok = ~addr_lo[0];
        case (mode)
            MODE_RD_WORD: acc_ok = word_ok;
            MODE_WR_BYTE: acc_ok = 1'b1;
            MODE_WR_HALF: acc_ok = half_ok;
            default:      acc_ok = word_ok;
        endcase
        misaligned = en && !acc_ok;
        read_ok    = en && (mode == MODE_RD_WORD) && word_ok;

        for (int i = 0; i < LANES; i++) begin
            case (mode)
                MODE_WR_BYTE: begin
                    lane_wdata[BYTE_W*i +: BYTE_W] = wdata[BYTE_W-1:0];
                    sel = (addr_lo == LSW'(i));
                end
                MODE_WR_HALF: begin
                    lane_wdata[BYTE_W*i +: BYTE_W] = wdata[BYTE_W*(i%2) +: BYTE_W];
                    sel = ((addr_lo >> 1) == (LSW'(i) >> 1));
                end
                MODE_WR_WORD: begin
                    lane_wdata[BYTE_W*i +: BYTE_W] = wdata[BYTE_W*i +: BYTE_W];
                    sel = 1'b1;
                end
                default: begin
                    lane_wdata[BYTE_W*i +: BYTE_W] = wdata[BYTE_W*i +: BYTE_W];
                    sel = 1'b0;
                end
            endcase
            lane_we[i] = en && acc_ok && sel;
        end
    end
endmodule

// File: rtl/mem_byte_lane.sv
module mem_byte_lane
    import mem_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte
);
    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wbyte;
        end
    end

    assign rbyte = cells[idx];
endmodule

// File: rtl/byte_data_mem.sv
module byte_data_mem
    import mem_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEPTH_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int LSW   = $clog2(LANES);
    localparam int WORDS = DEPTH_BYTES / LANES;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] lane_wdata;
    logic [DATA_W-1:0] lane_rdata;
    logic              misaligned;
    logic              read_ok;
    logic [IDX_W-1:0]  word_idx;
    logic              unused_hi_addr;

    mem_ctl_t ctl_d;
    mem_ctl_t ctl_q;

    assign word_idx       = addr[LSW +: IDX_W];
    assign unused_hi_addr = ^addr[ADDR_W-1:LSW+IDX_W];

    mem_access_decode #(
        .LANES (LANES),
        .LSW   (LSW)
    ) u_decode (
        .en         (en),
        .mode       (mem_mode_e'(mode)),
        .addr_lo    (addr[LSW-1:0]),
        .wdata      (wdata),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata),
        .misaligned (misaligned),
        .read_ok    (read_ok)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mem_byte_lane #(
            .DEPTH (WORDS)
        ) u_lane (
            .clk   (clk),
            .we    (lane_we[g]),
            .idx   (word_idx),
            .wbyte (lane_wdata[BYTE_W*g +: BYTE_W]),
            .rbyte (lane_rdata[BYTE_W*g +: BYTE_W])
        );
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = misaligned;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdata = read_ok ? lane_rdata : '0;
    assign err   = ctl_q.err;
endmodule

// File: rtl/mem_access_checker.sv
module mem_access_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic [1:0]  mode,
    input logic [31:0] addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        err
);
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !err);

    assert_disabled_no_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> rdata == 32'h0);

    assert_word_roundtrip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'b11 && addr[1:0] == 2'b00) ##1
        (en && mode == 2'b00 && addr == $past(addr)) |-> rdata == $past(wdata));

    assert_byte_roundtrip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'b01) ##1
        (en && mode == 2'b00 && addr[1:0] == 2'b00 && addr[31:2] == $past(addr[31:2]))
        |-> 8'(rdata >> {$past(addr[1:0]), 3'b000}) == $past(wdata[7:0]));

    assert_misaligned_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ((mode == 2'b10 && addr[0]) || (mode == 2'b11 && addr[1:0] != 2'b00))) |=> err);

    assert_bad_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'b00 && addr[1:0] != 2'b00) |-> (rdata == 32'h0) ##1 err);

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(en) && $past(mode) != 2'b01 && $past(addr[1:0]) != 2'b00);

    assert_quiet_otherwise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> rdata == 32'h0);
endmodule

bind byte_data_mem mem_access_checker u_access_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .mode  (mode),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .err   (err)
);

// File: tb/test_byte_data_mem.sv
`timescale 1ns/1ps
module test_byte_data_mem;
    localparam int DEPTH = 64;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        en    = 1'b0;
    logic [1:0]  mode  = 2'b00;
    logic [31:0] addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    logic [7:0] model [DEPTH];
    bit    exp_err  = 1'b0;
    string prev_req = "R9";
    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;

    always #2.5 clk = ~clk;

    byte_data_mem #(.DEPTH_BYTES(DEPTH)) i_byte_data_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .mode  (mode),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .err   (err)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(string req, bit e, logic [1:0] m, logic [31:0] a, logic [31:0] d);
        int          b;
        bit          bad;
        logic [31:0] exp_rd;
        @(negedge clk);
        en = e; mode = m; addr = a; wdata = d;
        #1;
        b   = int'(a & 32'(DEPTH - 1));
        bad = ((m == 2'b00 || m == 2'b11) && a[1:0] != 2'b00) || (m == 2'b10 && a[0]);
        exp_rd = '0;
        if (e && m == 2'b00 && !bad)
            exp_rd = {model[b+3], model[b+2], model[b+1], model[b]};
        check(req, "rdata", rdata, exp_rd);
        check(prev_req, "err", {31'b0, err}, {31'b0, exp_err});
        exp_err  = e && bad;
        prev_req = req;
        if (e && !bad) begin
            case (m)
                2'b01: model[b] = d[7:0];
                2'b10: begin model[b] = d[7:0]; model[b+1] = d[15:8]; end
                2'b11: begin
                    model[b] = d[7:0];   model[b+1] = d[15:8];
                    model[b+2] = d[23:16]; model[b+3] = d[31:24];
                end
                default: ;
            endcase
        end
    endtask

    task automatic read_all(string req);
        for (int w = 0; w < DEPTH / 4; w++) step(req, 1'b1, 2'b00, 32'(w * 4), 32'h0);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9", "err in reset", {31'b0, err}, 32'h0);
        check("R10", "rdata in reset", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int w = 0; w < DEPTH / 4; w++)
            step("R5", 1'b1, 2'b11, 32'(w * 4), 32'hA5C3_0000 ^ (32'(w) * 32'h0101_0101));
        read_all("R2");

        step("R1", 1'b0, 2'b11, 32'h0, 32'hDEAD_BEEF);
        step("R1", 1'b0, 2'b01, 32'h5, 32'h0000_0077);
        step("R1", 1'b0, 2'b00, 32'h0, 32'h0);
        step("R1", 1'b1, 2'b00, 32'h0, 32'h0);
        step("R1", 1'b1, 2'b00, 32'h4, 32'h0);

        step("R3", 1'b1, 2'b01, 32'h5, 32'hFFFF_FF11);
        step("R3", 1'b1, 2'b01, 32'h7, 32'h0000_0022);
        step("R3", 1'b1, 2'b00, 32'h4, 32'h0);
        step("R3", 1'b1, 2'b01, 32'h4, 32'h1234_5633);
        step("R3", 1'b1, 2'b01, 32'h6, 32'h0000_0044);
        step("R3", 1'b1, 2'b00, 32'h4, 32'h0);

        step("R4", 1'b1, 2'b10, 32'h8, 32'hFFFF_BBAA);
        step("R4", 1'b1, 2'b00, 32'h8, 32'h0);
        step("R4", 1'b1, 2'b10, 32'hE, 32'h0000_DDCC);
        step("R4", 1'b1, 2'b00, 32'hC, 32'h0);

        step("R6", 1'b1, 2'b10, 32'h9, 32'h0000_9999);
        step("R6", 1'b1, 2'b11, 32'hD, 32'h7777_7777);
        step("R6", 1'b1, 2'b11, 32'h12, 32'h6666_6666);
        step("R6", 1'b1, 2'b00, 32'h8, 32'h0);
        step("R6", 1'b1, 2'b00, 32'hC, 32'h0);
        step("R6", 1'b1, 2'b00, 32'h10, 32'h0);

        step("R7", 1'b1, 2'b00, 32'h16, 32'h0);
        step("R7", 1'b1, 2'b00, 32'h13, 32'h0);
        step("R7", 1'b0, 2'b00, 32'h14, 32'h0);

        step("R8", 1'b1, 2'b11, 32'h1234_5670, 32'hC0DE_F00D);
        step("R8", 1'b1, 2'b00, 32'h0000_0030, 32'h0);
        step("R8", 1'b1, 2'b01, 32'hFFFF_FFF1, 32'h0000_00EE);
        step("R8", 1'b1, 2'b00, 32'h8000_0030, 32'h0);

        step("R9", 1'b1, 2'b11, 32'h20, 32'h0BAD_CAFE);
        step("R9", 1'b1, 2'b00, 32'h20, 32'h0);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra;
            ra = $urandom;
            if (n % 2 == 0) ra = ra & 32'h0000_003F;
            step("R10", ($urandom % 4) != 0, 2'($urandom), ra, $urandom);
        end
        read_all("R10");
        step("R10", 1'b0, 2'b00, 32'h0, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule